// File: doc/BRIEF.md
# Raster line and dot position interrupt unit

This unit watches the raster position reported by a video timing generator and raises single-cycle interrupt pulses when programmed positions are reached. Two independent vertical-position interrupts fire at dot 0 of their target lines. A third, horizontal-position interrupt fires at a programmed dot offset inside a target line. It can fire once per frame on a fixed line, every N lines with a target that advances and wraps, or on every line.

Targets are programmed in field-line units. A target n is mapped to raster line 2n in the even field and to 2n+1 in the odd field when interlacing is enabled. Two registers are written through a simple write port: one holds both vertical targets and one holds the horizontal configuration. Interrupt routing and the bus fabric sit outside this unit.

Top module: `raster_irq_unit`

## Requirements
- R1: A write with wr_sel_i=0 loads the vertical register: target A from wr_data_i[25:16] and target B from wr_data_i[9:0]. All other data bits are ignored.
- R2: A target n maps to raster line 2n+1 when interlace_i and field_odd_i are both 1, and to raster line 2n otherwise.
- R3: vline_a_irq_o (target A) and vline_b_irq_o (target B) pulse in the cycle after the raster reaches the mapped line with dot_i equal to 0, and at no other dot.
- R4: A target whose mapped line is greater than or equal to total_lines_i never fires.
- R5: A write with wr_sel_i=1 loads the horizontal register: line value in bits 9:0, mode in bits 13:12 and position in bits 25:16. All other data bits are ignored.
- R6: The horizontal interrupt dot is twice the position field, clamped to last_dot_i when it exceeds that value.
- R7: Modes 0 and 3 fire hpos_irq_o at the programmed dot of the mapped line each time the raster arrives there. The target does not change.
- R8: In mode 1, the first target is line_i/2 plus N, where N is the line value and line_i is sampled in the write cycle. The sum wraps as described in R9.
- R9: After each mode 1 or mode 2 firing, the target advances by N. A value above total_lines_i/2 has total_lines_i/2 subtracted once, so N must be at most total_lines_i/2.
- R10: Mode 2 behaves as mode 1 with N forced to 1, and the line value field is ignored.
- R11: A write re-arms the interrupts of the register written. No pulse from those interrupts appears in the cycle after the write, and a position held unchanged across the write does not fire until the raster leaves it and returns.
- R12: Each pulse lasts one cycle, and each arrival at a matching position produces one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | LINE_W | Current raster line |
| dot_i | input | DOT_W | Current dot within the line |
| field_odd_i | input | 1 | 1 while the odd field is scanned |
| interlace_i | input | 1 | 1 when interlaced scanning is enabled |
| total_lines_i | input | LINE_W | Raster lines per frame |
| last_dot_i | input | DOT_W | Index of the last dot of a line |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the vertical register, 1 the horizontal register |
| wr_data_i | input | REG_W | Register write data |
| vline_a_irq_o | output | 1 | Vertical interrupt A pulse |
| vline_b_irq_o | output | 1 | Vertical interrupt B pulse |
| hpos_irq_o | output | 1 | Horizontal position interrupt pulse |

## Verification
The bench drives the raster position directly and moves through a non-matching position between probes. This keeps every arrival distinct. The vertical targets are probed at dot 0 and at a neighbouring dot, in the even and odd fields, with interlacing on and off, and at the last valid line and one past it. These probes separate the field mapping from the line range check. The horizontal unit is tried in each mode. Repeated visits to the same position show whether the target stays fixed or advances, and a target chosen past half the frame exposes the wrap. Writes with the unused data bits set, and a write made while the raster sits on the new target, show that those bits have no effect and that a held match is not replayed.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  localparam int unsigned FIELD_W = 10;
  localparam int unsigned VA_LSB  = 16;
  localparam int unsigned VB_LSB  = 0;
  localparam int unsigned HL_LSB  = 0;
  localparam int unsigned HM_LSB  = 12;
  localparam int unsigned HP_LSB  = 16;
  localparam int unsigned NUM_V   = 2;

  typedef enum logic [1:0] {
    HMODE_FRAME      = 2'd0,
    HMODE_EVERY_N    = 2'd1,
    HMODE_EVERY_LINE = 2'd2,
    HMODE_RSVD       = 2'd3
  } hmode_e;
endpackage

// File: rtl/raster_line_map.sv
module raster_line_map #(
  parameter int unsigned LINE_W  = 11,
  parameter int unsigned FIELD_W = 10
) (
  input  logic [FIELD_W-1:0] tgt_i,
  input  logic               odd_i,
  input  logic [LINE_W-1:0]  total_i,
  output logic [LINE_W-1:0]  line_o,
  output logic               valid_o
);
  localparam int unsigned MAP_W = FIELD_W + 1;
  logic [MAP_W-1:0] map_w;
  assign map_w   = {tgt_i, odd_i};
  assign line_o  = LINE_W'(map_w);
  assign valid_o = line_o < total_i;
endmodule

// File: rtl/raster_edge_pulse.sv
module raster_edge_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic rearm_i,
  output logic fire_o,
  output logic pulse_o
);
  logic hit_q;

  assign fire_o = hit_i & ~hit_q & ~rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b1;
      pulse_o <= 1'b0;
    end else begin
      // a write treats the current position as already seen
      hit_q   <= rearm_i ? 1'b1 : hit_i;
      pulse_o <= fire_o;
    end
  end
endmodule

// File: rtl/raster_hpos_ctrl.sv
module raster_hpos_ctrl
  import raster_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned DOT_W  = 11,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              odd_i,
  input  logic [LINE_W-1:0] total_i,
  input  logic [DOT_W-1:0]  last_dot_i,
  output logic              irq_o
);
  localparam int unsigned DBL_W = FIELD_W + 1;

  hmode_e             mode_q;
  logic [FIELD_W-1:0] step_q, tgt_q, pos_q;

  logic [FIELD_W-1:0] w_line, w_pos, w_step;
  hmode_e             w_mode;
  logic               w_per_n, per_n;
  logic [LINE_W-1:0]  half, w_base, adv_base;
  logic [LINE_W-1:0]  map_line;
  logic               map_ok;
  logic [DBL_W-1:0]   dbl_pos;
  logic [DOT_W-1:0]   dot_tgt;
  logic               hit, fire;

  function automatic logic [FIELD_W-1:0] wrap_fn(input logic [LINE_W-1:0] x,
                                                 input logic [LINE_W-1:0] h);
    logic [LINE_W-1:0] r;
    r = (x > h) ? (x - h) : x;
    return r[FIELD_W-1:0];
  endfunction

  assign half     = total_i >> 1;
  assign w_line   = wr_data_i[HL_LSB +: FIELD_W];
  assign w_pos    = wr_data_i[HP_LSB +: FIELD_W];
  assign w_mode   = hmode_e'(wr_data_i[HM_LSB +: 2]);
  assign w_per_n  = (w_mode == HMODE_EVERY_N) || (w_mode == HMODE_EVERY_LINE);
  assign w_step   = (w_mode == HMODE_EVERY_LINE) ? FIELD_W'(1) : w_line;
  assign w_base   = (line_i >> 1) + LINE_W'(w_step);
  assign adv_base = LINE_W'(tgt_q) + LINE_W'(step_q);
  assign per_n    = (mode_q == HMODE_EVERY_N) || (mode_q == HMODE_EVERY_LINE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= HMODE_FRAME;
      step_q <= '0;
      tgt_q  <= '0;
      pos_q  <= '0;
    end else if (wr_i) begin
      mode_q <= w_mode;
      step_q <= w_step;
      pos_q  <= w_pos;
      tgt_q  <= w_per_n ? wrap_fn(w_base, half) : w_line;
    end else if (fire && per_n) begin
      tgt_q  <= wrap_fn(adv_base, half);
    end
  end

  raster_line_map #(.LINE_W(LINE_W), .FIELD_W(FIELD_W)) u_map (
    .tgt_i   (tgt_q),
    .odd_i   (odd_i),
    .total_i (total_i),
    .line_o  (map_line),
    .valid_o (map_ok)
  );

  assign dbl_pos = {pos_q, 1'b0};
  assign dot_tgt = (DOT_W'(dbl_pos) > last_dot_i) ? last_dot_i : DOT_W'(dbl_pos);
  assign hit     = map_ok && (line_i == map_line) && (dot_i == dot_tgt);

  raster_edge_pulse u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .rearm_i (wr_i),
    .fire_o  (fire),
    .pulse_o (irq_o)
  );
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
  import raster_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned DOT_W  = 11,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              field_odd_i,
  input  logic              interlace_i,
  input  logic [LINE_W-1:0] total_lines_i,
  input  logic [DOT_W-1:0]  last_dot_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              vline_a_irq_o,
  output logic              vline_b_irq_o,
  output logic              hpos_irq_o
);
  localparam int unsigned VSEL_LSB [NUM_V] = '{VA_LSB, VB_LSB};

  logic                            odd_eff, wr_v, wr_h;
  logic [NUM_V-1:0][FIELD_W-1:0]   vtgt_q;
  logic [NUM_V-1:0]                virq;

  assign odd_eff = field_odd_i & interlace_i;
  assign wr_v    = wr_en_i & ~wr_sel_i;
  assign wr_h    = wr_en_i &  wr_sel_i;

  for (genvar g = 0; g < NUM_V; g++) begin : g_vline
    logic [LINE_W-1:0] map_line;
    logic              map_ok, hit, fire_unused;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   vtgt_q[g] <= '0;
      else if (wr_v) vtgt_q[g] <= wr_data_i[VSEL_LSB[g] +: FIELD_W];
    end

    raster_line_map #(.LINE_W(LINE_W), .FIELD_W(FIELD_W)) u_map (
      .tgt_i   (vtgt_q[g]),
      .odd_i   (odd_eff),
      .total_i (total_lines_i),
      .line_o  (map_line),
      .valid_o (map_ok)
    );

    assign hit = map_ok && (line_i == map_line) && (dot_i == '0);

    raster_edge_pulse u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit),
      .rearm_i (wr_v),
      .fire_o  (fire_unused),
      .pulse_o (virq[g])
    );
  end

  assign vline_a_irq_o = virq[0];
  assign vline_b_irq_o = virq[1];

  raster_hpos_ctrl #(.LINE_W(LINE_W), .DOT_W(DOT_W), .REG_W(REG_W)) u_hpos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_h),
    .wr_data_i  (wr_data_i),
    .line_i     (line_i),
    .dot_i      (dot_i),
    .odd_i      (odd_eff),
    .total_i    (total_lines_i),
    .last_dot_i (last_dot_i),
    .irq_o      (hpos_irq_o)
  );
endmodule

// File: rtl/raster_irq_unit_chk.sv
module raster_irq_unit_chk #(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned DOT_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] line_i,
  input logic [DOT_W-1:0]  dot_i,
  input logic              interlace_i,
  input logic [LINE_W-1:0] total_lines_i,
  input logic [DOT_W-1:0]  last_dot_i,
  input logic              wr_en_i,
  input logic              vline_a_irq_o,
  input logic              vline_b_irq_o,
  input logic              hpos_irq_o
);
  AST_VA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vline_a_irq_o |=> !vline_a_irq_o); // R12
  AST_VB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vline_b_irq_o |=> !vline_b_irq_o); // R12
  AST_H_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_irq_o |=> !hpos_irq_o); // R12
  AST_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !(vline_a_irq_o || vline_b_irq_o || hpos_irq_o)); // R11
  AST_VA_DOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vline_a_irq_o |-> $past(dot_i) == '0); // R3
  AST_VB_DOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vline_b_irq_o |-> $past(dot_i) == '0); // R3
  AST_VA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vline_a_irq_o |-> $past(line_i) < $past(total_lines_i)); // R4
  AST_H_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_irq_o |-> $past(line_i) < $past(total_lines_i)); // R4
  AST_H_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_irq_o |-> $past(dot_i) <= $past(last_dot_i)); // R6
  AST_VA_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vline_a_irq_o && !$past(interlace_i)) |-> !$past(line_i[0])); // R2
endmodule

bind raster_irq_unit raster_irq_unit_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_i        (line_i),
  .dot_i         (dot_i),
  .interlace_i   (interlace_i),
  .total_lines_i (total_lines_i),
  .last_dot_i    (last_dot_i),
  .wr_en_i       (wr_en_i),
  .vline_a_irq_o (vline_a_irq_o),
  .vline_b_irq_o (vline_b_irq_o),
  .hpos_irq_o    (hpos_irq_o)
);

// File: tb/raster_irq_unit_test.sv
`timescale 1ns/1ps
module raster_irq_unit_test;
  localparam int unsigned LINE_W = 11;
  localparam int unsigned DOT_W  = 11;
  localparam int unsigned REG_W  = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [LINE_W-1:0] line_i = '0;
  logic [DOT_W-1:0]  dot_i = 11'd5;
  logic              field_odd_i = 1'b0;
  logic              interlace_i = 1'b0;
  logic [LINE_W-1:0] total_lines_i = 11'd20;
  logic [DOT_W-1:0]  last_dot_i = 11'd40;
  logic              wr_en_i = 1'b0;
  logic              wr_sel_i = 1'b0;
  logic [REG_W-1:0]  wr_data_i = '0;
  logic              vline_a_irq_o, vline_b_irq_o, hpos_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  raster_irq_unit #(.LINE_W(LINE_W), .DOT_W(DOT_W), .REG_W(REG_W)) uut (
    .clk_i, .rst_ni, .line_i, .dot_i, .field_odd_i, .interlace_i,
    .total_lines_i, .last_dot_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .vline_a_irq_o, .vline_b_irq_o, .hpos_irq_o
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {vline_a_irq_o, vline_b_irq_o, hpos_irq_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: irq {a,b,h} actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic at(input int l, input int d);
    line_i = LINE_W'(l);
    dot_i  = DOT_W'(d);
  endtask

  // idle on a position no target uses, then visit the probe position
  task automatic probe(input int l, input int d, input logic [2:0] exp, input string req);
    at(0, 39);
    step();
    at(l, d);
    step();
    check(req, exp);
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] data);
    wr_en_i   = 1'b1;
    wr_sel_i  = sel;
    wr_data_i = data;
    step();
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic t_reset();
    check("R12 reset", 3'b000);
  endtask

  task automatic t_vertical();
    interlace_i = 0; field_odd_i = 0;
    at(0, 5);
    write_reg(1'b0, (32'd3 << 16) | 32'd9);
    check("R11 write cycle", 3'b000);
    probe(6, 1, 3'b000, "R3 dot not zero");
    probe(6, 0, 3'b100, "R1 R3 target A");
    step(); check("R12 held", 3'b000);
    probe(18, 0, 3'b010, "R1 R3 target B");
    probe(7, 0, 3'b000, "R2 odd line no interlace");
  endtask

  task automatic t_interlace();
    interlace_i = 1; field_odd_i = 1;
    probe(6, 0, 3'b000, "R2 odd field even line");
    probe(7, 0, 3'b100, "R2 odd field 2n+1");
    field_odd_i = 0;
    probe(6, 0, 3'b100, "R2 even field 2n");
    interlace_i = 0; field_odd_i = 1;
    probe(7, 0, 3'b000, "R2 field ignored progressive");
    probe(6, 0, 3'b100, "R2 progressive 2n");
    field_odd_i = 0;
  endtask

  task automatic t_range();
    interlace_i = 1; field_odd_i = 0;
    write_reg(1'b0, (32'd10 << 16) | 32'd9);
    probe(20, 0, 3'b000, "R4 mapped equals total");
    probe(18, 0, 3'b010, "R4 below total");
    field_odd_i = 1;
    probe(19, 0, 3'b010, "R4 last line odd");
    probe(21, 0, 3'b000, "R4 beyond total");
    interlace_i = 0; field_odd_i = 0;
  endtask

  task automatic t_vmask();
    write_reg(1'b0, 32'hFC00_FC00 | (32'd2 << 16) | 32'd7);
    probe(4, 0, 3'b100, "R1 masked A");
    probe(14, 0, 3'b010, "R1 masked B");
  endtask

  task automatic t_rearm();
    write_reg(1'b0, (32'd2 << 16) | 32'd9);
    at(6, 0);
    step();
    write_reg(1'b0, (32'd3 << 16) | 32'd9);
    check("R11 after write", 3'b000);
    step(); check("R11 held not replayed", 3'b000);
    probe(6, 0, 3'b100, "R11 returns");
  endtask

  task automatic t_hmode0();
    write_reg(1'b1, 32'hFC00_CC00 | (32'd5 << 16) | 32'd4);
    probe(8, 9, 3'b000, "R5 wrong dot");
    probe(8, 10, 3'b001, "R5 R7 mode 0");
    step(); check("R12 h held", 3'b000);
    probe(8, 10, 3'b001, "R7 fixed target");
    write_reg(1'b1, (32'd100 << 16) | 32'd4);
    probe(8, 39, 3'b000, "R6 before clamp");
    probe(8, 40, 3'b001, "R6 clamp to line end");
    write_reg(1'b1, (32'd5 << 16) | (32'd3 << 12) | 32'd4);
    probe(8, 10, 3'b001, "R7 mode 3");
    probe(8, 10, 3'b001, "R7 mode 3 repeat");
  endtask

  task automatic t_hmode1();
    at(6, 20);
    write_reg(1'b1, (32'd5 << 16) | (32'd1 << 12) | 32'd4);
    probe(8, 10, 3'b000, "R8 not line field");
    probe(14, 10, 3'b001, "R8 first target");
    probe(14, 10, 3'b000, "R9 advanced");
    probe(2, 10, 3'b001, "R9 wrapped");
    probe(10, 10, 3'b001, "R9 advance by N");
    at(16, 5);
    write_reg(1'b1, (32'd5 << 16) | (32'd1 << 12) | 32'd4);
    probe(4, 10, 3'b001, "R8 initial wrap");
  endtask

  task automatic t_hmode2();
    at(8, 3);
    write_reg(1'b1, (32'd5 << 16) | (32'd2 << 12) | 32'd9);
    probe(10, 10, 3'b001, "R10 first line");
    probe(12, 10, 3'b001, "R10 next line");
    probe(10, 10, 3'b000, "R10 old line");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_vertical();
    t_interlace();
    t_range();
    t_vmask();
    t_rearm();
    t_hmode0();
    t_hmode1();
    t_hmode2();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule